// File: doc/BRIEF.md
# External Interrupt Detection Unit

This unit turns one non-maskable interrupt pin and eight maskable interrupt pins into request signals for a downstream interrupt controller. Each pin is first brought into the clock domain through a synchronizer. The non-maskable pin sets a pending latch on a software-selected edge, and the acknowledge input clears it. Each maskable pin is sensed either by level (active low) or by its falling edge.

Software reaches the unit through a simple synchronous register port. `reg_addr` = 0 selects the control register and `reg_addr` = 1 selects the status register. Read data is combinational on the selected address. The control register holds the sensing modes and shows the synchronized non-maskable pin level. The status register shows one request flag per maskable input. A flag captured on an edge is withdrawn by a read that returns 1 followed by a write of 0. Standby entry is signalled on `stby_clr` and empties every stored flag.

Each maskable input runs its own state machine with three states:

- FLG_IDLE: no request is held.
- FLG_HELD: a request is held and has not yet been seen by software.
- FLG_ARMED: a held request has been read as 1.

Its transitions are:

- FLG_IDLE to FLG_HELD on a synchronized falling edge.
- FLG_HELD to FLG_ARMED on a status read.
- FLG_ARMED to FLG_IDLE on a write of 0 to its bit.
- FLG_ARMED to FLG_HELD when that write coincides with a new edge.
- Any state to FLG_IDLE on standby or while the input is in level mode.

The non-maskable machine has two states, NMI_CLEAR and NMI_PENDING. It moves NMI_CLEAR to NMI_PENDING on the selected edge, and NMI_PENDING to NMI_CLEAR on acknowledge unless an edge arrives in the same cycle.

Top module: `ext_irq_detect`

## Requirements
- R1: Control bit 15 reads the synchronized level of `nmi_pin`. Writing it has no effect.
- R2: Control bit 8 selects the non-maskable edge: 0 is falling (reset value) and 1 is rising. The opposite edge does not set the pending latch.
- R3: Control bits 14 to 9 always read 0, whatever was written to them.
- R4: Control bit 7-i selects the sensing of IRQ input i: 0 is low level (reset value) and 1 is falling edge.
- R5: Status bits 15 to 8 always read 0.
- R6: Status bit 7-i is the flag of IRQ input i, and `irq_req[i]` equals that flag. After reset all stored flags are 0.
- R7: In edge mode a synchronized falling edge sets the flag, and the flag stays set. A write of 0 that is not preceded by a read returning 1 leaves it set.
- R8: After a status read returns 1 for a flag, a write with that bit at 0 clears the flag and a write with that bit at 1 keeps it.
- R9: A new edge in the same cycle as the clearing write keeps the flag set. The flag then needs a fresh read before a write of 0 can clear it.
- R10: In level mode the flag is 1 exactly while the synchronized pin is low, and writes to the status register do not clear it.
- R11: `nmi_pend` sets on the selected edge and holds until `nmi_ack`. An edge in the same cycle as `nmi_ack` keeps it set.
- R12: A `stby_clr` pulse clears every edge-mode flag and its armed state, and leaves the control register unchanged.
- R13: A pin change reaches a level-mode flag and control bit 15 two clocks later, and an edge-mode flag or `nmi_pend` three clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_clr | input | 1 | One-cycle pulse on standby entry; clears stored flags |
| nmi_pin | input | 1 | Non-maskable interrupt pin, asynchronous |
| irq_pin | input | 8 | Maskable interrupt pins, index = IRQ number, asynchronous |
| reg_addr | input | 1 | 0 = control register, 1 = status register |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register, combinational |
| nmi_ack | input | 1 | One-cycle acknowledge that clears the pending latch |
| nmi_pend | output | 1 | Non-maskable request pending |
| irq_req | output | 8 | Maskable request lines, index = IRQ number |

## Verification
Several behaviours are checked by assertions on every cycle. These are:

- the zero reserved fields of both registers;
- a held edge flag surviving any cycle without standby;
- the priority of a new edge over a clearing write;
- the pending latch holding until acknowledge and setting after a detected edge;
- the emptying of edge flags after standby.

Other behaviours show only in the bench's scenarios against its cycle-by-cycle model: the read-then-write-zero order, the exact two- and three-clock latencies, the reversed bit order, the edge polarity choice and level-mode immunity to writes.

// File: rtl/eid_pkg.sv
`timescale 1ns/1ps
package eid_pkg;
    typedef enum logic [1:0] {
        FLG_IDLE  = 2'd0,
        FLG_HELD  = 2'd1,
        FLG_ARMED = 2'd2
    } flg_state_t;

    typedef enum logic {
        NMI_CLEAR   = 1'b0,
        NMI_PENDING = 1'b1
    } nmi_state_t;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;
    localparam int unsigned CTRL_LVL_BIT  = 15;
    localparam int unsigned CTRL_EDGE_BIT = 8;
endpackage

// File: rtl/eid_sync.sv
`timescale 1ns/1ps
module eid_sync #(
    parameter int unsigned WIDTH  = 9,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_q;
    logic [WIDTH-1:0]             prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q  <= '1;
            prev_q <= '1;
        end else begin
            stg_q[0] <= pin_i;
            for (int s = 1; s < int'(STAGES); s++) begin
                stg_q[s] <= stg_q[s-1];
            end
            prev_q <= stg_q[STAGES-1];
        end
    end

    assign sync_o = stg_q[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/eid_flag_fsm.sv
`timescale 1ns/1ps
module eid_flag_fsm
    import eid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_mode,
    input  logic fall_evt,
    input  logic pin_low,
    input  logic rd_stat,
    input  logic wr_zero,
    input  logic stby_clr,
    output logic flag_o
);
    flg_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (stby_clr || !edge_mode) begin
            state_d = FLG_IDLE;
        end else begin
            unique case (state_q)
                FLG_IDLE:  if (fall_evt) state_d = FLG_HELD;
                FLG_HELD:  if (rd_stat)  state_d = FLG_ARMED;
                FLG_ARMED: if (wr_zero)  state_d = fall_evt ? FLG_HELD : FLG_IDLE;
                default:   state_d = FLG_IDLE;
            endcase
        end
    end

    always_comb begin
        flag_o = edge_mode ? (state_q != FLG_IDLE) : pin_low;
    end

    // R7: a held edge request survives every cycle without standby
    a_r7_held_survives: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && state_q == FLG_HELD && !stby_clr) |=> (!edge_mode || flag_o));

    // R9: a new edge coinciding with the clearing write wins and disarms
    a_r9_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && state_q == FLG_ARMED && wr_zero && fall_evt && !stby_clr)
        |=> (state_q == FLG_HELD));
endmodule

// File: rtl/eid_nmi_fsm.sv
`timescale 1ns/1ps
module eid_nmi_fsm
    import eid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise_sel,
    input  logic lvl,
    input  logic lvl_prev,
    input  logic ack,
    output logic pend_o
);
    nmi_state_t state_q, state_d;
    logic       edge_hit;

    assign edge_hit = rise_sel ? (lvl & ~lvl_prev) : (~lvl & lvl_prev);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= NMI_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NMI_CLEAR:   if (edge_hit)         state_d = NMI_PENDING;
            NMI_PENDING: if (ack && !edge_hit) state_d = NMI_CLEAR;
            default:     state_d = NMI_CLEAR;
        endcase
    end

    always_comb begin
        pend_o = (state_q == NMI_PENDING);
    end

    // R11: pending holds until acknowledge
    a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !ack) |=> pend_o);

    // R11: a detected edge always leaves a pending request
    a_r11_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> pend_o);
endmodule

// File: rtl/ext_irq_detect.sv
`timescale 1ns/1ps
module ext_irq_detect
    import eid_pkg::*;
#(
    parameter int unsigned N_IRQ       = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned REG_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stby_clr,
    input  logic             nmi_pin,
    input  logic [N_IRQ-1:0] irq_pin,
    input  logic             reg_addr,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             nmi_ack,
    output logic             nmi_pend,
    output logic [N_IRQ-1:0] irq_req
);
    localparam int unsigned PIN_W    = N_IRQ + 1;
    localparam int unsigned STAT_TOP = N_IRQ - 1;

    logic [PIN_W-1:0] pin_sync, pin_prev;
    logic             esel_q;
    logic [N_IRQ-1:0] mode_q;
    logic             ctrl_wr, stat_wr, stat_rd;
    logic             unused_wdata;

    assign ctrl_wr      = reg_wr && (reg_addr == ADDR_CTRL);
    assign stat_wr      = reg_wr && (reg_addr == ADDR_STAT);
    assign stat_rd      = reg_rd && (reg_addr == ADDR_STAT);
    assign unused_wdata = ^reg_wdata[REG_W-1:CTRL_EDGE_BIT+1];

    eid_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({nmi_pin, irq_pin}),
        .sync_o (pin_sync),
        .prev_o (pin_prev)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            esel_q <= 1'b0;
            mode_q <= '0;
        end else if (ctrl_wr) begin
            esel_q <= reg_wdata[CTRL_EDGE_BIT];
            for (int i = 0; i < int'(N_IRQ); i++) begin
                mode_q[i] <= reg_wdata[STAT_TOP-i];
            end
        end
    end

    generate
        for (genvar g = 0; g < int'(N_IRQ); g++) begin : g_irq
            logic fall_evt, wr_zero;
            assign fall_evt = pin_prev[g] & ~pin_sync[g];
            assign wr_zero  = stat_wr & ~reg_wdata[STAT_TOP-g];
            eid_flag_fsm u_flag (
                .clk       (clk),
                .rst_n     (rst_n),
                .edge_mode (mode_q[g]),
                .fall_evt  (fall_evt),
                .pin_low   (~pin_sync[g]),
                .rd_stat   (stat_rd),
                .wr_zero   (wr_zero),
                .stby_clr  (stby_clr),
                .flag_o    (irq_req[g])
            );
        end
    endgenerate

    eid_nmi_fsm u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_sel (esel_q),
        .lvl      (pin_sync[N_IRQ]),
        .lvl_prev (pin_prev[N_IRQ]),
        .ack      (nmi_ack),
        .pend_o   (nmi_pend)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CTRL) begin
            reg_rdata[CTRL_LVL_BIT]  = pin_sync[N_IRQ];
            reg_rdata[CTRL_EDGE_BIT] = esel_q;
            for (int i = 0; i < int'(N_IRQ); i++) reg_rdata[STAT_TOP-i] = mode_q[i];
        end else begin
            for (int i = 0; i < int'(N_IRQ); i++) reg_rdata[STAT_TOP-i] = irq_req[i];
        end
    end

    // R3: reserved control field reads zero
    a_r3_ctrl_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_CTRL) |-> (reg_rdata[CTRL_LVL_BIT-1:CTRL_EDGE_BIT+1] == '0));

    // R5: upper status byte reads zero
    a_r5_stat_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_STAT) |-> (reg_rdata[REG_W-1:N_IRQ] == '0));

    // R12: standby empties every edge-mode flag
    a_r12_standby_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stby_clr |=> ((irq_req & mode_q) == '0));
endmodule

// File: tb/ext_irq_detect_tb.sv
`timescale 1ns/1ps
module ext_irq_detect_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stby_clr = 1'b0;
    logic        nmi_pin = 1'b1;
    logic [7:0]  irq_pin = 8'hFF;
    logic        reg_addr = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        nmi_ack = 1'b0;
    logic        nmi_pend;
    logic [7:0]  irq_req;

    always #2 clk = ~clk;

    ext_irq_detect u_dut (
        .clk(clk), .rst_n(rst_n), .stby_clr(stby_clr), .nmi_pin(nmi_pin),
        .irq_pin(irq_pin), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_ack(nmi_ack),
        .nmi_pend(nmi_pend), .irq_req(irq_req)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [8:0] hist[$];       // pin samples, newest first; [8]=nmi
    int         st[8];         // 0 none, 1 held, 2 armed
    bit         m_pend;
    bit         m_esel;
    bit [7:0]   m_mode;        // index = IRQ number, 1 = edge

    function automatic logic m_flag(input int i);
        return m_mode[i] ? (st[i] != 0) : ~hist[1][i];
    endfunction

    function automatic logic [15:0] m_rdata(input logic a);
        logic [15:0] r;
        r = 16'h0;
        if (a == 1'b0) begin
            r[15] = hist[1][8];
            r[8]  = m_esel;
            for (int i = 0; i < 8; i++) r[7-i] = m_mode[i];
        end else begin
            for (int i = 0; i < 8; i++) r[7-i] = m_flag(i);
        end
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist = {9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF};
            for (int i = 0; i < 8; i++) st[i] = 0;
            m_pend = 1'b0;
            m_esel = 1'b0;
            m_mode = 8'h0;
        end else begin
            logic [8:0] s2, pv;
            logic       nedge, rd_s, wr_s;
            s2   = hist[1];
            pv   = hist[2];
            rd_s = reg_rd && reg_addr;
            wr_s = reg_wr && reg_addr;
            for (int i = 0; i < 8; i++) begin
                logic fall, wz;
                fall = pv[i] && !s2[i];
                wz   = wr_s && !reg_wdata[7-i];
                if (stby_clr || !m_mode[i]) st[i] = 0;
                else if (st[i] == 0) begin if (fall) st[i] = 1; end
                else if (st[i] == 1) begin if (rd_s) st[i] = 2; end
                else if (wz) st[i] = fall ? 1 : 0;
            end
            nedge = m_esel ? (!pv[8] && s2[8]) : (pv[8] && !s2[8]);
            if (nedge) m_pend = 1'b1;
            else if (nmi_ack) m_pend = 1'b0;
            if (reg_wr && !reg_addr) begin
                m_esel = reg_wdata[8];
                for (int i = 0; i < 8; i++) m_mode[i] = reg_wdata[7-i];
            end
            hist.push_front({nmi_pin, irq_pin});
            void'(hist.pop_back());
        end
    end

    // cycle-by-cycle comparison
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic [7:0] ex;
            for (int i = 0; i < 8; i++) ex[i] = m_flag(i);
            check("R6 model irq_req", irq_req, ex);
            check("R11 model nmi_pend", nmi_pend, m_pend);
            check("R1 model reg_rdata", reg_rdata, m_rdata(reg_addr));
        end
    end

    // ---------------- stimulus helpers (called at negedge) ----------------
    task automatic bus_wr(input logic a, input logic [15:0] d);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic a, input string req, input logic [15:0] exp);
        reg_addr = a; reg_rd = 1'b1;
        #1 check(req, reg_rdata, exp);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R13 actual=hung expected=finished");
            done = 1'b1;
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd_chk(1'b0, "R1 R2 R4 reset control", 16'h8000);
        rd_chk(1'b1, "R6 reset status", 16'h0000);
        check("R11 reset nmi_pend", nmi_pend, 1'b0);

        // reserved and read-only control bits
        bus_wr(1'b0, 16'h7FFF);
        rd_chk(1'b0, "R3 reserved control bits", 16'h81FF);
        rd_chk(1'b1, "R5 reserved status bits", 16'h0000);
        bus_wr(1'b0, 16'h8000);
        rd_chk(1'b0, "R4 level mode restored", 16'h8000);

        // NMI falling edge, level view, acknowledge
        nmi_pin = 1'b0;
        tick(3);
        rd_chk(1'b0, "R1 pin level low", 16'h0000);
        check("R2 falling edge sets", nmi_pend, 1'b1);
        nmi_ack = 1'b1; @(negedge clk); nmi_ack = 1'b0;
        check("R11 ack clears", nmi_pend, 1'b0);
        nmi_pin = 1'b1;
        tick(3);
        check("R2 rising edge ignored when falling selected", nmi_pend, 1'b0);
        bus_wr(1'b0, 16'h0100);
        nmi_pin = 1'b0;
        tick(3);
        check("R2 falling ignored when rising selected", nmi_pend, 1'b0);
        nmi_pin = 1'b1;
        tick(3);
        check("R2 rising edge sets", nmi_pend, 1'b1);
        tick(4);
        check("R11 holds without ack", nmi_pend, 1'b1);
        nmi_ack = 1'b1; @(negedge clk); nmi_ack = 1'b0;

        // level mode, latency
        irq_pin[0] = 1'b0;
        @(posedge clk); #1 check("R13 level one clock", irq_req[0], 1'b0);
        @(posedge clk); #1 check("R13 level two clocks", irq_req[0], 1'b1);
        @(negedge clk);
        rd_chk(1'b1, "R6 IRQ0 at bit 7", 16'h0080);
        bus_wr(1'b1, 16'h0000);
        check("R10 write ignored in level mode", irq_req[0], 1'b1);
        irq_pin[0] = 1'b1;
        tick(3);
        check("R10 level released", irq_req[0], 1'b0);

        // edge mode hold, arm, clear
        bus_wr(1'b0, 16'h01FF);
        irq_pin[2] = 1'b0; tick(2); irq_pin[2] = 1'b1; tick(3);
        check("R7 edge sets flag", irq_req, 8'h04);
        bus_wr(1'b1, 16'h0000);
        check("R7 unarmed write keeps flag", irq_req[2], 1'b1);
        rd_chk(1'b1, "R6 IRQ2 at bit 5", 16'h0020);
        bus_wr(1'b1, 16'h0020);
        check("R8 write of one keeps flag", irq_req[2], 1'b1);
        bus_wr(1'b1, 16'h0000);
        check("R8 armed write of zero clears", irq_req[2], 1'b0);

        irq_pin[3] = 1'b0;
        @(posedge clk); #1 check("R13 edge one clock", irq_req[3], 1'b0);
        @(posedge clk); #1 check("R13 edge two clocks", irq_req[3], 1'b0);
        @(posedge clk); #1 check("R13 edge three clocks", irq_req[3], 1'b1);
        @(negedge clk);
        irq_pin[3] = 1'b1;

        // edge coinciding with clearing write
        irq_pin[5] = 1'b0; tick(2); irq_pin[5] = 1'b1; tick(3);
        rd_chk(1'b1, "R9 flags before race", 16'h0014);
        irq_pin[5] = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        reg_addr = 1'b1; reg_wr = 1'b1; reg_wdata = 16'h0000;
        @(posedge clk); #1 check("R9 edge beats clear", irq_req[5], 1'b1);
        check("R8 IRQ3 cleared by same write", irq_req[3], 1'b0);
        @(negedge clk); reg_wr = 1'b0;
        bus_wr(1'b1, 16'h0000);
        check("R9 disarmed after race", irq_req[5], 1'b1);
        irq_pin[5] = 1'b1; tick(3);

        // standby
        rd_chk(1'b1, "R12 before standby", 16'h0004);
        stby_clr = 1'b1; @(negedge clk); stby_clr = 1'b0;
        check("R12 standby clears flags", irq_req, 8'h00);
        rd_chk(1'b0, "R12 control kept", 16'h81FF);

        // random traffic against the model
        for (int c = 0; c < 3000; c++) begin
            int k;
            @(negedge clk);
            reg_rd = 1'b0; reg_wr = 1'b0; nmi_ack = 1'b0; stby_clr = 1'b0;
            k = $urandom_range(0, 7);
            if ($urandom_range(0, 2) == 0) irq_pin[k] = ~irq_pin[k];
            if ($urandom_range(0, 12) == 0) nmi_pin = ~nmi_pin;
            reg_addr = 1'($urandom_range(0, 1));
            case ($urandom_range(0, 9))
                0, 1: begin reg_addr = 1'b1; reg_rd = 1'b1; end
                2, 3: begin reg_addr = 1'b1; reg_wr = 1'b1; reg_wdata = 16'($urandom()); end
                4: if ($urandom_range(0, 9) == 0) begin
                       reg_addr = 1'b0; reg_wr = 1'b1;
                       reg_wdata = 16'($urandom()) | 16'h00F0;
                   end
                5: nmi_ack = 1'b1;
                6: if ($urandom_range(0, 15) == 0) stby_clr = 1'b1;
                default: ;
            endcase
        end
        @(negedge clk);
        reg_rd = 1'b0; reg_wr = 1'b0; nmi_ack = 1'b0; stby_clr = 1'b0;
        tick(4);
        done = 1'b1;
        finish_run();
    end
endmodule